// File: doc/BRIEF.md
# CSR Access Permission Gate

This block is a purely combinational gate placed in front of a control and status register file. For each access request it decides whether the access may proceed. If the access may not proceed, it raises an illegal-instruction indication and holds back the write enable. The decision uses four things: the 12-bit register number, whether the access intends to write, the current privilege level and virtualization state of the hart, and which privilege extensions are present.

The gate first raises the hart's privilege by one level when a supervisor runs unvirtualized on a hart that has the hypervisor extension. This makes the hypervisor-level registers reachable from that mode. A debugger access skips the privilege comparison. It does not skip the read-only rule or the hypervisor-class restriction. The gate also reports whether the addressed register belongs to the hypervisor/virtual-supervisor class. It holds no state, and every output follows its inputs within the same cycle.

Top module: `csr_access_gate`

## Requirements
- R1: The required privilege of a register is its number's bits [9:8]. With the debugger flag clear, an access is refused when the effective privilege is numerically below that value.
- R2: A register whose number has bits [11:10] equal to 3 is read-only. A write-intent access to it is refused even when the debugger flag is set. A read of it is not refused by this rule.
- R3: Privilege is encoded U=0, S=1, M=3. The effective privilege is 2 when the hart is in S (1) with virtualization clear and the hypervisor extension present. In every other case it equals the current privilege, so M is never raised.
- R4: With the debugger flag set, the privilege comparison of R1 never refuses an access.
- R5: A register is of hypervisor class when its number has bits [9:8] equal to 2, or when the number is 0x34A or 0x34B. Such a register is refused unless both the S and H extension flags are set and the hart is in M, or in S with virtualization clear. This rule applies even with the debugger flag set.
- R6: The illegal output is high exactly when a request is present and the access is refused. The write enable is high exactly when a request with write intent is present and the access is allowed. With no request, both are low.
- R7: The class output reports the R5 class membership of the register number, whatever the privilege, virtualization or extension inputs.
- R8: The block has no storage, so a change on any input is reflected on the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| csr_addr_i | input | 12 | Register number of the access |
| csr_req_i | input | 1 | An access is being made this cycle |
| wr_req_i | input | 1 | The access intends to write |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| virt_i | input | 1 | Hart runs virtualized |
| dbg_i | input | 1 | Access comes from the debugger |
| ext_s_i | input | 1 | Supervisor extension present |
| ext_h_i | input | 1 | Hypervisor extension present |
| allow_o | output | 1 | Access permitted by all rules |
| illegal_o | output | 1 | Requested access is refused |
| wr_en_o | output | 1 | Write may be committed |
| hyp_class_o | output | 1 | Register belongs to the hypervisor class |
| eff_priv_o | output | 2 | Effective privilege used for comparison |

## Verification
A table of vectors walks the same register numbers through U, S with and without virtualization, and M. This separates the raised effective privilege of an unvirtualized supervisor from that of a guest. It also covers the hypervisor extension being absent or present. Debugger vectors pair with read-only writes and with hypervisor-class accesses from U or a guest. These show that the debugger skips only the privilege comparison. Read-versus-write pairs on the same read-only number isolate the write-intent rule. The two machine-level numbers in the hypervisor class are tested with the extension on and off. Directed steps with no request present check that illegal and write enable stay low.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;
  localparam int unsigned CSR_ADDR_W = 12;
  localparam int unsigned PRIV_W     = 2;

  localparam logic [PRIV_W-1:0] PRIV_U  = 2'd0;
  localparam logic [PRIV_W-1:0] PRIV_S  = 2'd1;
  localparam logic [PRIV_W-1:0] PRIV_HS = 2'd2;
  localparam logic [PRIV_W-1:0] PRIV_M  = 2'd3;

  // bit fields of the register number
  localparam int unsigned LVL_LSB = 8;
  localparam int unsigned ACC_LSB = 10;
  localparam logic [1:0]  ACC_RO  = 2'b11;
  localparam logic [1:0]  LVL_HYP = 2'b10;
endpackage

// File: rtl/csr_eff_priv.sv
module csr_eff_priv
  import csr_gate_pkg::*;
(
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              virt_i,
  input  logic              ext_h_i,
  output logic [PRIV_W-1:0] eff_priv_o
);
  logic raise;

  assign raise = ext_h_i && !virt_i && (priv_i == PRIV_S);

  always_comb begin
    eff_priv_o = raise ? PRIV_HS : priv_i;
    if (!$isunknown({priv_i, virt_i, ext_h_i})) begin
      p_m_saturates_r3: assert (priv_i != PRIV_M || eff_priv_o == PRIV_M)
        else $error("effective privilege left M");
    end
  end
endmodule

// File: rtl/csr_num_decode.sv
module csr_num_decode
  import csr_gate_pkg::*;
#(
  parameter logic [CSR_ADDR_W-1:0] XTRA_HYP_BASE = 12'h34A,
  parameter int unsigned           XTRA_HYP_CNT  = 2
) (
  input  logic [CSR_ADDR_W-1:0] csr_addr_i,
  output logic [PRIV_W-1:0]     req_priv_o,
  output logic                  read_only_o,
  output logic                  hyp_class_o
);
  localparam logic [CSR_ADDR_W:0] XTRA_END = {1'b0, XTRA_HYP_BASE} + CSR_ADDR_W'(XTRA_HYP_CNT);

  logic in_xtra;

  assign req_priv_o  = csr_addr_i[LVL_LSB +: PRIV_W];
  assign read_only_o = csr_addr_i[ACC_LSB +: 2] == ACC_RO;
  assign in_xtra     = (csr_addr_i >= XTRA_HYP_BASE) &&
                       ({1'b0, csr_addr_i} < XTRA_END);
  assign hyp_class_o = (csr_addr_i[LVL_LSB +: PRIV_W] == LVL_HYP) || in_xtra;
endmodule

// File: rtl/csr_verdict.sv
module csr_verdict
  import csr_gate_pkg::*;
(
  input  logic [PRIV_W-1:0] eff_priv_i,
  input  logic [PRIV_W-1:0] req_priv_i,
  input  logic              read_only_i,
  input  logic              hyp_class_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              virt_i,
  input  logic              dbg_i,
  input  logic              wr_req_i,
  input  logic              ext_s_i,
  input  logic              ext_h_i,
  output logic              allow_o
);
  logic ro_block, lvl_block, hyp_ok, hyp_block;

  assign ro_block  = read_only_i && wr_req_i;
  assign lvl_block = !dbg_i && (eff_priv_i < req_priv_i);
  assign hyp_ok    = ext_s_i && ext_h_i &&
                     ((priv_i == PRIV_M) || (priv_i == PRIV_S && !virt_i));
  assign hyp_block = hyp_class_i && !hyp_ok;
  assign allow_o   = !(ro_block || lvl_block || hyp_block);
endmodule

// File: rtl/csr_access_gate.sv
module csr_access_gate
  import csr_gate_pkg::*;
(
  input  logic [11:0] csr_addr_i,
  input  logic        csr_req_i,
  input  logic        wr_req_i,
  input  logic [1:0]  priv_i,
  input  logic        virt_i,
  input  logic        dbg_i,
  input  logic        ext_s_i,
  input  logic        ext_h_i,
  output logic        allow_o,
  output logic        illegal_o,
  output logic        wr_en_o,
  output logic        hyp_class_o,
  output logic [1:0]  eff_priv_o
);
  logic [PRIV_W-1:0] eff_priv, req_priv;
  logic              read_only, hyp_class, allow;

  csr_eff_priv u_eff (
    .priv_i     (priv_i),
    .virt_i     (virt_i),
    .ext_h_i    (ext_h_i),
    .eff_priv_o (eff_priv)
  );

  csr_num_decode u_dec (
    .csr_addr_i  (csr_addr_i),
    .req_priv_o  (req_priv),
    .read_only_o (read_only),
    .hyp_class_o (hyp_class)
  );

  csr_verdict u_vrd (
    .eff_priv_i  (eff_priv),
    .req_priv_i  (req_priv),
    .read_only_i (read_only),
    .hyp_class_i (hyp_class),
    .priv_i      (priv_i),
    .virt_i      (virt_i),
    .dbg_i       (dbg_i),
    .wr_req_i    (wr_req_i),
    .ext_s_i     (ext_s_i),
    .ext_h_i     (ext_h_i),
    .allow_o     (allow)
  );

  assign allow_o     = allow;
  assign illegal_o   = csr_req_i && !allow;
  assign wr_en_o     = csr_req_i && wr_req_i && allow;
  assign hyp_class_o = hyp_class;
  assign eff_priv_o  = eff_priv;

  always_comb begin
    if (!$isunknown({csr_addr_i, csr_req_i, wr_req_i, priv_i, virt_i,
                     dbg_i, ext_s_i, ext_h_i})) begin
      p_lvl_gate_r1: assert (dbg_i || !allow_o || eff_priv >= req_priv)
        else $error("allowed below required level");
      p_ro_write_r2: assert (!(read_only && wr_req_i) || !allow_o)
        else $error("write to read-only allowed");
      p_hyp_ext_r5: assert (!(hyp_class && allow_o) || (ext_s_i && ext_h_i))
        else $error("hypervisor register allowed without extensions");
      p_out_excl_r6: assert (!(illegal_o && wr_en_o))
        else $error("illegal and write enable together");
      p_idle_r6: assert (csr_req_i || (!illegal_o && !wr_en_o))
        else $error("output active without request");
    end
  end
endmodule

// File: tb/csr_access_gate_test.sv
module csr_access_gate_test;
  typedef struct packed {
    logic [11:0] addr;
    logic        wr;
    logic [1:0]  priv;
    logic        virt;
    logic        dbg;
    logic        s;
    logic        h;
    logic        allow;
    logic [1:0]  eff;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [0:NV-1] = '{
    '{12'h300, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3}, // R1 M reads M reg
    '{12'h300, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2}, // R1 HS below M
    '{12'h100, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1}, // R3 S no H
    '{12'h100, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0}, // R1 U below S
    '{12'h600, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2}, // R3 HS reaches hyp
    '{12'h600, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1}, // R3 no H, no raise
    '{12'h600, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1}, // R3 guest not raised
    '{12'h600, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3}, // R5 M ok
    '{12'h600, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3}, // R5 S ext missing
    '{12'hC00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0}, // R2 read of RO ok
    '{12'hC00, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd3}, // R2 write of RO
    '{12'hF11, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3}, // R2 debugger RO write
    '{12'h300, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0}, // R4 debugger bypass
    '{12'h600, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0}, // R5 debugger in U
    '{12'h200, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2}, // R5 HS guest reg
    '{12'h200, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1}, // R5 debugger in guest
    '{12'hA00, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3}, // R5 M hyp rw
    '{12'h7B0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3}, // R1 M level no ext
    '{12'h34A, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3}, // R5 extra hyp no H
    '{12'h34B, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3}, // R5 extra hyp ok
    '{12'h34A, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2}  // R4 dbg HS extra
  };

  logic        clk = 1'b0;
  logic [11:0] csr_addr;
  logic        csr_req, wr_req, virt, dbg, ext_s, ext_h;
  logic [1:0]  priv;
  logic        allow, illegal, wr_en, hyp_class;
  logic [1:0]  eff_priv;
  int          n_chk = 0, n_bad = 0;
  int          cycles = 0;

  always #2 clk = ~clk;

  csr_access_gate uut (
    .csr_addr_i  (csr_addr),
    .csr_req_i   (csr_req),
    .wr_req_i    (wr_req),
    .priv_i      (priv),
    .virt_i      (virt),
    .dbg_i       (dbg),
    .ext_s_i     (ext_s),
    .ext_h_i     (ext_h),
    .allow_o     (allow),
    .illegal_o   (illegal),
    .wr_en_o     (wr_en),
    .hyp_class_o (hyp_class),
    .eff_priv_o  (eff_priv)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic hyp_exp(input logic [11:0] a);
    return (a[9:8] == 2'b10) || (a == 12'h34A) || (a == 12'h34B);
  endfunction

  task automatic drive(input vec_t v, input logic req);
    @(negedge clk);
    csr_addr = v.addr; wr_req = v.wr; priv = v.priv; virt = v.virt;
    dbg = v.dbg; ext_s = v.s; ext_h = v.h; csr_req = req;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual %0d expected below 5000 cycles", cycles);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    csr_addr = '0; csr_req = 1'b0; wr_req = 1'b0; priv = 2'd0;
    virt = 1'b0; dbg = 1'b0; ext_s = 1'b0; ext_h = 1'b0;
    #1;
    chk("R6 idle illegal", int'(illegal), 0);
    chk("R6 idle wr_en", int'(wr_en), 0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 1'b1);
      chk($sformatf("R1/R2/R4/R5 allow v%0d", i), int'(allow), int'(VECS[i].allow));
      chk($sformatf("R3 eff v%0d", i), int'(eff_priv), int'(VECS[i].eff));
      chk($sformatf("R6 illegal v%0d", i), int'(illegal), int'(!VECS[i].allow));
      chk($sformatf("R6 wr_en v%0d", i), int'(wr_en), int'(VECS[i].wr && VECS[i].allow));
      chk($sformatf("R7 class v%0d", i), int'(hyp_class), int'(hyp_exp(VECS[i].addr)));
    end

    // R6: refused write with no request raises nothing
    drive(VECS[10], 1'b0);
    chk("R6 no req illegal", int'(illegal), 0);
    chk("R6 no req wr_en", int'(wr_en), 0);
    chk("R6 no req allow", int'(allow), 0);

    // R8: output follows input between edges, no clock needed
    drive(VECS[4], 1'b1);
    chk("R8 before", int'(wr_en), 1);
    virt = 1'b1;
    #0.5;
    chk("R8 after virt flip", int'(wr_en), 0);
    chk("R8 eff after flip", int'(eff_priv), 1);

    // R7: class independent of privilege inputs
    csr_addr = 12'h680; priv = 2'd0; ext_s = 1'b0; ext_h = 1'b0; #0.5;
    chk("R7 class in U", int'(hyp_class), 1);
    csr_addr = 12'h34C; priv = 2'd3; #0.5;
    chk("R7 past extra range", int'(hyp_class), 0);
    csr_addr = 12'h349; #0.5;
    chk("R7 below extra range", int'(hyp_class), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule